// File: doc/BRIEF.md
# Linear Sensor Section Sequencer

This block is the digital control of one section of a linear image sensor with a fixed number of pixels (128 by default). A single-cycle start pulse on `serIn`, captured at a rising clock edge, begins an output cycle. At that capture edge a global hold strobe freezes every pixel's sampled value. The selected pixel index then walks from the first pixel to the last, one pixel per clock. An enable marks the window in which the analog output would be driven.

For the first 18 clocks of the cycle a global integrator reset is held. Integration for the next frame resumes at the 19th clock. When the token reaches the last pixel it appears on `serOut` for one clock. Wiring `serOut` into the `serIn` of a second section chains the two into one serial frame. Photodiodes and analog levels are not modelled.

Top module: `lss_seq_top`

## Requirements
- R1: After reset, `outEn`, `serOut`, `holdStrobe`, `intReset` and `protoErr` are 0 and `pixelSel` is 0 until the first start pulse.
- R2: When `serIn` is 1 at a rising edge (edge 1 of the cycle), the following cycle shows `holdStrobe`=1, `outEn`=1 and `pixelSel`=0. `holdStrobe` stays high for that single cycle only.
- R3: During a cycle, each later rising edge raises `pixelSel` by one, up to 127 (the last pixel) after edge 128.
- R4: `intReset` is 1 after edges 1 through 18 of a cycle and 0 from edge 19 onward.
- R5: `serOut` is 1 only in the cycle after edge 128 and returns to 0 at edge 129.
- R6: At edge 129, with no new start pulse, `outEn` drops to 0 and `pixelSel` returns to 0.
- R7: With two sections chained (first `serOut` into second `serIn`), the second section's `serOut` falls at edge 257, counted from the capture edge of the first section.
- R8: A start pulse at an edge where the cycle has shown pixels 0 to 126 restarts the cycle at pixel 0 (as in R2) and sets `protoErr`. A start pulse at edge 129, while `serOut` is high, restarts without setting `protoErr`.
- R9: `protoErr` stays 1 until reset, whatever the later stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| serIn | input | 1 | Start pulse, one cycle wide |
| pixelSel | output | 7 | Index of the pixel currently selected for output |
| outEn | output | 1 | Output window active (analog output driven) |
| holdStrobe | output | 1 | One-cycle global hold at cycle start |
| intReset | output | 1 | Global integrator reset level |
| serOut | output | 1 | Token out at the last pixel, for cascading |
| protoErr | output | 1 | Sticky flag for a start pulse during a running cycle |

## Verification
All outputs are registered state, so each result is due in the cycle after the edge that causes it:
- hold, enable and pixel 0 one edge after capture;
- pixel k after edge k+1;
- reset release after edge 19;
- `serOut` after edge 128 and its release at edge 129.

The bench drives `serIn` and compares every output at the falling edge against a behavioural position model that it advances on each rising edge. A second chained section has its own model. The bench counts edges from the first capture to the second section's token release to confirm 257.

// File: rtl/lss_seq_pkg.sv
package lss_seq_pkg;
  typedef struct packed {
    logic load;   // start a cycle at the first pixel
    logic adv;    // move to next pixel
    logic clr;    // end of cycle, go idle
    logic err;    // start pulse arrived mid-cycle
  } seqStrobe_t;
endpackage

// File: rtl/lss_seq_ctrl.sv
module lss_seq_ctrl #(
  parameter int PIXELS = 128,
  localparam int CNT_W = $clog2(PIXELS + 1)
) (
  input  logic                      serIn,
  input  logic [CNT_W-1:0]          posCnt,
  output lss_seq_pkg::seqStrobe_t   strobe
);
  logic idle;
  logic atLast;

  assign idle   = (posCnt == '0);
  assign atLast = (posCnt == CNT_W'(PIXELS));

  always_comb begin
    strobe.load = serIn;
    strobe.adv  = !serIn && !idle && !atLast;
    strobe.clr  = !serIn && atLast;
    strobe.err  = serIn && !idle && !atLast;
  end
endmodule

// File: rtl/lss_seq_dp.sv
module lss_seq_dp #(
  parameter int PIXELS     = 128,
  parameter int RESET_CLKS = 18,
  localparam int CNT_W = $clog2(PIXELS + 1),
  localparam int SEL_W = $clog2(PIXELS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  lss_seq_pkg::seqStrobe_t strobe,
  output logic [CNT_W-1:0]        posCnt,
  output logic [SEL_W-1:0]        pixelSel,
  output logic                    outEn,
  output logic                    holdStrobe,
  output logic                    intReset,
  output logic                    serOut,
  output logic                    protoErr
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posCnt <= '0;
    end else if (strobe.load) begin
      posCnt <= CNT_W'(1);
    end else if (strobe.adv) begin
      posCnt <= posCnt + CNT_W'(1);
    end else if (strobe.clr) begin
      posCnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) protoErr <= 1'b0;
    else if (strobe.err) protoErr <= 1'b1;
  end

  assign outEn      = (posCnt != '0);
  assign pixelSel   = outEn ? SEL_W'(posCnt - CNT_W'(1)) : '0;
  assign holdStrobe = (posCnt == CNT_W'(1));
  assign intReset   = outEn && (posCnt <= CNT_W'(RESET_CLKS));
  assign serOut     = (posCnt == CNT_W'(PIXELS));
endmodule

// File: rtl/lss_seq_top.sv
module lss_seq_top #(
  parameter int PIXELS     = 128,
  parameter int RESET_CLKS = 18,
  localparam int CNT_W = $clog2(PIXELS + 1),
  localparam int SEL_W = $clog2(PIXELS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serIn,
  output logic [SEL_W-1:0] pixelSel,
  output logic             outEn,
  output logic             holdStrobe,
  output logic             intReset,
  output logic             serOut,
  output logic             protoErr
);
  lss_seq_pkg::seqStrobe_t strobe;
  logic [CNT_W-1:0] posCnt;

  lss_seq_ctrl #(.PIXELS(PIXELS)) uCtrl (
    .serIn (serIn),
    .posCnt(posCnt),
    .strobe(strobe)
  );

  lss_seq_dp #(.PIXELS(PIXELS), .RESET_CLKS(RESET_CLKS)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .posCnt    (posCnt),
    .pixelSel  (pixelSel),
    .outEn     (outEn),
    .holdStrobe(holdStrobe),
    .intReset  (intReset),
    .serOut    (serOut),
    .protoErr  (protoErr)
  );
endmodule

// File: rtl/lss_seq_checker.sv
module lss_seq_checker #(
  parameter int PIXELS = 128,
  localparam int SEL_W = $clog2(PIXELS)
) (
  input logic             clk,
  input logic             rstN,
  input logic             serIn,
  input logic [SEL_W-1:0] pixelSel,
  input logic             outEn,
  input logic             holdStrobe,
  input logic             intReset,
  input logic             serOut,
  input logic             protoErr
);
  assert_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    serIn |=> (holdStrobe && outEn && pixelSel == '0 && intReset));

  assert_hold_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    (holdStrobe && !serIn) |=> !holdStrobe);

  assert_advance_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outEn && !serIn && pixelSel != SEL_W'(PIXELS - 1)) |=>
      (outEn && pixelSel == $past(pixelSel) + SEL_W'(1)));

  assert_token_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    (serOut && !serIn) |=> (!serOut && !outEn));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |-> (!serOut && !intReset && !holdStrobe && pixelSel == '0));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);
endmodule

bind lss_seq_top lss_seq_checker #(.PIXELS(PIXELS)) uChk (
  .clk(clk), .rstN(rstN), .serIn(serIn), .pixelSel(pixelSel),
  .outEn(outEn), .holdStrobe(holdStrobe), .intReset(intReset),
  .serOut(serOut), .protoErr(protoErr)
);

// File: tb/lss_seq_top_test.sv
module lss_seq_top_test;
  localparam int N = 128;
  localparam int RST = 18;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serIn = 1'b0;
  logic [6:0] selA, selB;
  logic enA, enB, holdA, holdB, irA, irB, soA, soB, errA, errB;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  lss_seq_top uut (
    .clk(clk), .rstN(rstN), .serIn(serIn), .pixelSel(selA), .outEn(enA),
    .holdStrobe(holdA), .intReset(irA), .serOut(soA), .protoErr(errA));

  lss_seq_top uutB (
    .clk(clk), .rstN(rstN), .serIn(soA), .pixelSel(selB), .outEn(enB),
    .holdStrobe(holdB), .intReset(irB), .serOut(soB), .protoErr(errB));

  // behavioural model: position = number of edges since capture (0 = idle)
  int posA = 0, posB = 0;
  bit mErrA = 0, mErrB = 0;
  int edgeCnt = 0;
  int bFallEdge = -1;
  bit trackFrame = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posA = 0; posB = 0; mErrA = 0; mErrB = 0;
    end else begin
      bit siB;
      siB = (posA == N);
      if (serIn) begin
        if (posA != 0 && posA != N) mErrA = 1;
        posA = 1;
      end else if (posA == N) posA = 0;
      else if (posA != 0) posA = posA + 1;
      if (siB) begin
        if (posB != 0 && posB != N) mErrB = 1;
        posB = 1;
      end else if (posB == N) posB = 0;
      else if (posB != 0) posB = posB + 1;
      if (trackFrame) edgeCnt = edgeCnt + 1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmpSection(int pos, bit merr, logic [6:0] sel, logic en, logic hd,
                            logic ir, logic so, logic er);
    chk("R3 pixelSel", sel, (pos == 0) ? 0 : pos - 1);
    chk("R6 outEn", en, pos != 0);
    chk("R2 holdStrobe", hd, pos == 1);
    chk("R4 intReset", ir, pos >= 1 && pos <= RST);
    chk("R5 serOut", so, pos == N);
    chk("R8 R9 protoErr", er, merr);
  endtask

  bit prevSoB = 0;
  always @(negedge clk) begin
    if (rstN) begin
      cmpSection(posA, mErrA, selA, enA, holdA, irA, soA, errA);
      cmpSection(posB, mErrB, selB, enB, holdB, irB, soB, errB);
      if (trackFrame && prevSoB && !soB && bFallEdge < 0) bFallEdge = edgeCnt;
    end
    prevSoB = soB;
  end

  task automatic pulse(int cycles);
    @(negedge clk); serIn = 1'b1;
    @(negedge clk); serIn = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    #1;
    // R1: reset state
    chk("R1 outEn", enA, 0); chk("R1 serOut", soA, 0); chk("R1 pixelSel", selA, 0);
    chk("R1 intReset", irA, 0); chk("R1 hold", holdA, 0); chk("R1 protoErr", errA, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 idle outEn", enA, 0);

    // R7: full cascaded frame, capture edge counted as edge 1
    @(negedge clk); serIn = 1'b1; trackFrame = 1;
    @(negedge clk); serIn = 1'b0;
    repeat (270) @(negedge clk);
    chk("R7 second section token release edge", bFallEdge, 2 * N + 1);
    trackFrame = 0;

    // R8: restart at edge 129 (token high) is clean
    @(negedge clk); serIn = 1'b1;
    @(negedge clk); serIn = 1'b0;
    repeat (N - 1) @(negedge clk);
    chk("R5 token present before back-to-back start", soA, 1);
    serIn = 1'b1;
    @(negedge clk); serIn = 1'b0;
    chk("R8 clean restart pixelSel", selA, 0);
    chk("R8 clean restart no error", errA, 0);
    repeat (300) @(negedge clk);

    // R8: mid-cycle restart sets error
    pulse(40);
    serIn = 1'b1;
    @(negedge clk); serIn = 1'b0;
    chk("R8 mid-cycle restart pixelSel", selA, 0);
    chk("R8 mid-cycle error", errA, 1);
    repeat (300) @(negedge clk);

    // R9: error stays through further clean frames
    pulse(300);
    chk("R9 protoErr sticky", errA, 1);

    // R8: start held two cycles counts as a violation in a fresh run
    rstN = 1'b0; @(negedge clk); rstN = 1'b1;
    @(negedge clk); serIn = 1'b1;
    @(negedge clk);
    @(negedge clk); serIn = 1'b0;
    chk("R8 wide pulse error", errA, 1);
    chk("R8 wide pulse pixelSel", selA, 0);
    repeat (300) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule